// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller Pair

This block joins two eight-input priority interrupt controllers in a master/slave arrangement. The slave resolves its own eight request lines and presents a single request to input 2 of the master. The master resolves its inputs and raises one interrupt line toward the processor. Software reaches either controller through a byte-wide write/read port that has a controller select and an address bit. On that port it runs a four-word initialization sequence, sets request masks, reads back the in-service state and issues end-of-interrupt commands.

The processor answers an interrupt with two single-cycle acknowledge pulses. On the first pulse the master records its winning input and, when that input carries a slave, posts the input number as a cascade code. On the second pulse the slave compares the code with its own identification number. If they match, the slave supplies the vector from its own base. Otherwise the master supplies it. Request lines are level sensitive. Priority is fixed, with input 0 highest.

Top module: `pic_cascade`

## Requirements
- R1: After reset, and until a unit finishes initialization, `cpu_int` and `vec_valid` stay low, the mask reads 00h and writes to the odd address are ignored.
- R2: A write to the even address with bit 4 set begins initialization and clears that unit's mask and in-service bits. The next three odd-address writes are taken in this order. The first gives the vector base (bits 7:3). The second is the cascade word: for the master, a bitmap of inputs that carry a slave (04h); for the slave, its identification code in bits 2:0 (02h). The third is the mode word: bit 1 selects automatic end of interrupt and bit 4 selects special fully nested mode. After that, odd writes reach the mask.
- R3: A 1 in a mask bit blocks the matching request, a 0 re-enables it, and the mask reads back at the odd address.
- R4: Input 0 has the highest priority and input 7 the lowest. A request is granted only when no in-service bit is set at its own or a higher priority.
- R5: The vector is {base, granted input number}, and it is valid for one cycle, the cycle after the second acknowledge pulse.
- R6: Master input 2 is driven only by the slave, and `irq_lines[2]` has no effect. When the master grants input 2, the slave matches the cascade code and returns {slave base, slave input number}.
- R7: Master mask bit 2 blocks every slave request.
- R8: In-service bits read back at the even address. The master sets its bit on the first pulse and the slave sets its bit on the second. A write of 20h clears the highest-priority set bit. A write of 60h+n clears bit n. At most one bit is newly set in a cycle.
- R9: When automatic end of interrupt is selected, in-service bits are clear again once the acknowledge sequence ends.
- R10: In special fully nested mode, the master grants a new slave request while its input 2 is already in service.
- R11: An acknowledge with nothing pending returns {master base, 7} and sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Controller select: 0 master, 1 slave |
| bus_a0 | input | 1 | Register address bit |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data (odd: mask, even: in-service) |
| irq_lines | input | 16 | Request lines; 7:0 master (bit 2 unused), 15:8 slave |
| cpu_int | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge pulse, two per sequence |
| vec_valid | output | 1 | Vector valid strobe |
| vec | output | 8 | Interrupt vector |

## Verification
Two actions fall in the same cycle: the slave setting its in-service bit on the matching second pulse, and the automatic end of interrupt clearing that bit. Both happen on the same edge. This case is provoked by programming automatic end of interrupt and raising slave lines, in directed runs and in random runs. The outcome is judged on three points: the vector must carry the slave base and the slave's line number, the slave in-service register must read back as zero, and a later lower-priority slave request must still be granted.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    CF_OFF,
    CF_BASE,
    CF_CASC,
    CF_MODE,
    CF_RUN
  } cfg_state_e;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  isr,
  input  logic [N-1:0]  casc,
  input  logic          en,
  input  logic          sfnm,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic blk;

  always_comb begin
    any = 1'b0;
    idx = '0;
    blk = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!any && !blk && en && req[i] && !mask[i] && (!isr[i] || (sfnm && casc[i]))) begin
        any = 1'b1;
        idx = IW'(i);
      end
      if (isr[i]) blk = 1'b1;
    end
  end
endmodule

// File: rtl/pic_cfg.sv
module pic_cfg import pic_pkg::*; #(
  parameter int N  = 8,
  parameter int VW = 8,
  localparam int IW = $clog2(N),
  localparam int BW = VW - IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          a0,
  input  logic [7:0]    wdata,
  output logic [N-1:0]  mask,
  output logic [BW-1:0] base,
  output logic [N-1:0]  casc_map,
  output logic          aeoi,
  output logic          sfnm,
  output logic          ready,
  output logic          init_clr,
  output logic          eoi_hit,
  output logic          eoi_spec,
  output logic [IW-1:0] eoi_lvl
);
  cfg_state_e st;

  assign ready = (st == CF_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CF_OFF;
      mask     <= '0;
      base     <= '0;
      casc_map <= '0;
      aeoi     <= 1'b0;
      sfnm     <= 1'b0;
      init_clr <= 1'b0;
      eoi_hit  <= 1'b0;
      eoi_spec <= 1'b0;
      eoi_lvl  <= '0;
    end else begin
      init_clr <= 1'b0;
      eoi_hit  <= 1'b0;
      if (wr && !a0 && wdata[4]) begin
        st       <= CF_BASE;
        mask     <= '0;
        init_clr <= 1'b1;
      end else if (wr && !a0 && wdata[4:3] == 2'b00 && st == CF_RUN) begin
        if (wdata[7:5] == 3'b001) begin
          eoi_hit  <= 1'b1;
          eoi_spec <= 1'b0;
        end else if (wdata[7:5] == 3'b011) begin
          eoi_hit  <= 1'b1;
          eoi_spec <= 1'b1;
          eoi_lvl  <= wdata[IW-1:0];
        end
      end else if (wr && a0) begin
        case (st)
          CF_BASE: begin base <= wdata[7:IW]; st <= CF_CASC; end
          CF_CASC: begin casc_map <= wdata[N-1:0]; st <= CF_MODE; end
          CF_MODE: begin aeoi <= wdata[1]; sfnm <= wdata[4]; st <= CF_RUN; end
          CF_RUN:  mask <= wdata[N-1:0];
          default: ;
        endcase
      end
    end
  end

  // R2
  icw_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !a0 && wdata[4]) |=> (mask == '0) && !ready);
endmodule

// File: rtl/pic_unit.sv
module pic_unit #(
  parameter int N  = 8,
  parameter int VW = 8,
  parameter bit IS_MASTER = 1'b1,
  localparam int IW = $clog2(N),
  localparam int BW = VW - IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          a0,
  input  logic [7:0]    wdata,
  output logic [7:0]    rd_val,
  input  logic [N-1:0]  req,
  input  logic          take,
  input  logic          finish,
  input  logic [IW-1:0] cas_in,
  output logic          any,
  output logic          casc_hit,
  output logic [IW-1:0] code_out,
  output logic [BW-1:0] base,
  output logic [N-1:0]  isr
);
  logic [N-1:0]  mask, casc_map, casc_eff, isr_n;
  logic          aeoi, sfnm, ready, init_clr, eoi_hit, eoi_spec, found, lat_hit;
  logic [IW-1:0] eoi_lvl, idx, cur_code, lat_code;

  pic_cfg #(.N(N), .VW(VW)) u_cfg (
    .clk(clk), .rst(rst), .wr(wr), .a0(a0), .wdata(wdata),
    .mask(mask), .base(base), .casc_map(casc_map), .aeoi(aeoi), .sfnm(sfnm),
    .ready(ready), .init_clr(init_clr), .eoi_hit(eoi_hit), .eoi_spec(eoi_spec),
    .eoi_lvl(eoi_lvl)
  );

  assign casc_eff = IS_MASTER ? casc_map : '0;

  pic_prio #(.N(N)) u_prio (
    .req(req), .mask(mask), .isr(isr), .casc(casc_eff), .en(ready), .sfnm(sfnm),
    .any(any), .idx(idx)
  );

  assign cur_code = any ? idx : IW'(N - 1);
  assign code_out = take ? cur_code : lat_code;
  assign casc_hit = IS_MASTER ? (any && casc_map[idx]) : (casc_map[IW-1:0] == cas_in);
  assign rd_val   = a0 ? 8'(mask) : 8'(isr);

  always_comb begin
    isr_n = isr;
    found = 1'b0;
    if (eoi_hit) begin
      if (eoi_spec) isr_n[eoi_lvl] = 1'b0;
      else begin
        for (int i = 0; i < N; i++) begin
          if (!found && isr[i]) begin
            isr_n[i] = 1'b0;
            found    = 1'b1;
          end
        end
      end
    end
    if (take && any && !(finish && aeoi)) isr_n[idx] = 1'b1;
    if (finish && aeoi && !take && lat_hit) isr_n[lat_code] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr      <= '0;
      lat_code <= '0;
      lat_hit  <= 1'b0;
    end else begin
      isr <= init_clr ? '0 : isr_n;
      if (take) begin
        lat_code <= cur_code;
        lat_hit  <= any;
      end
    end
  end

  // R8
  isr_single_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(isr & ~$past(isr)) <= 1);
  // R3
  isr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((isr & ~$past(isr)) & $past(mask)) == '0);
  // R9
  aeoi_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (aeoi && $past(finish)) |-> (isr == '0));
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade #(
  parameter int N       = 8,
  parameter int VW      = 8,
  parameter int CASC_IN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_a0,
  input  logic            bus_wr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [2*N-1:0]  irq_lines,
  output logic            cpu_int,
  input  logic            ack,
  output logic            vec_valid,
  output logic [VW-1:0]   vec
);
  localparam int IW = $clog2(N);
  localparam int BW = VW - IW;

  logic          phase, ack1, ack2, cas_valid, s_take, s_int;
  logic [IW-1:0] cas_code, m_code, s_code;
  logic [BW-1:0] m_base, s_base;
  logic [N-1:0]  m_req, m_isr, s_isr;
  logic [7:0]    m_rd, s_rd;
  logic          m_any, s_any, m_hit, s_hit;

  assign ack1   = ack && !phase;
  assign ack2   = ack && phase;
  assign s_take = ack2 && cas_valid && s_hit;

  always_comb begin
    m_req          = irq_lines[N-1:0];
    m_req[CASC_IN] = s_int;
  end

  pic_unit #(.N(N), .VW(VW), .IS_MASTER(1'b1)) u_master (
    .clk(clk), .rst(rst), .wr(bus_wr && !bus_sel), .a0(bus_a0), .wdata(bus_wdata),
    .rd_val(m_rd), .req(m_req), .take(ack1), .finish(ack2), .cas_in('0),
    .any(m_any), .casc_hit(m_hit), .code_out(m_code), .base(m_base), .isr(m_isr)
  );

  pic_unit #(.N(N), .VW(VW), .IS_MASTER(1'b0)) u_slave (
    .clk(clk), .rst(rst), .wr(bus_wr && bus_sel), .a0(bus_a0), .wdata(bus_wdata),
    .rd_val(s_rd), .req(irq_lines[2*N-1:N]), .take(s_take), .finish(s_take),
    .cas_in(cas_code), .any(s_any), .casc_hit(s_hit), .code_out(s_code),
    .base(s_base), .isr(s_isr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= 1'b0;
      cas_valid <= 1'b0;
      cas_code  <= '0;
      vec       <= '0;
      vec_valid <= 1'b0;
      cpu_int   <= 1'b0;
      s_int     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= bus_sel ? s_rd : m_rd;
      s_int     <= s_any;
      cpu_int   <= m_any;
      vec_valid <= ack2;
      if (ack) phase <= !phase;
      if (ack1) begin
        cas_valid <= m_hit;
        cas_code  <= m_code;
      end else if (ack2) begin
        cas_valid <= 1'b0;
      end
      if (ack2) vec <= s_take ? {s_base, s_code} : {m_base, m_code};
    end
  end

  // R6
  slave_gate_chk: assert property (@(posedge clk) disable iff (rst)
    s_take |-> m_isr[CASC_IN]);
  // R8
  slave_isr_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(|s_isr) |-> $past(s_take));
  // R5
  vec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);
endmodule

// File: tb/pic_cascade_test.sv
`timescale 1ns/100ps
module pic_cascade_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_a0 = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] irq_lines = '0;
  logic        cpu_int, ack = 1'b0, vec_valid;
  logic [7:0]  vec;

  int errors = 0;
  int checks = 0;

  // bench model
  logic [15:0] lines_m = '0;
  logic [7:0]  mmask = '0, smask = '0, misr = '0, sisr = '0;
  logic [4:0]  mbase = '0, sbase = '0;
  bit          aeoi_m = 0, sfnm_m = 0, ready_m = 0;

  always #2.5 clk = ~clk;

  pic_cascade uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_a0(bus_a0), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .cpu_int(cpu_int), .ack(ack), .vec_valid(vec_valid), .vec(vec)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int win(input logic [7:0] req, input logic [7:0] msk,
                             input logic [7:0] isr, input bit sf2);
    for (int i = 0; i < 8; i++) begin
      if (req[i] && !msk[i] && (!isr[i] || (sf2 && i == 2))) return i;
      if (isr[i]) return 8;
    end
    return 8;
  endfunction

  function automatic int s_win();
    return ready_m ? win(lines_m[15:8], smask, sisr, 1'b0) : 8;
  endfunction

  function automatic int m_win();
    logic [7:0] r;
    r = lines_m[7:0];
    r[2] = (s_win() != 8);
    return ready_m ? win(r, mmask, misr, sfnm_m) : 8;
  endfunction

  function automatic int low_bit(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  task automatic wr_bus(input logic sel, input logic a0, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_a0 = a0; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_bus(input logic sel, input logic a0, output logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_a0 = a0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic set_lines(input logic [15:0] v);
    @(negedge clk);
    irq_lines = v;
    lines_m   = v;
  endtask

  task automatic check_int(input string tag);
    repeat (4) @(negedge clk);
    chk(tag, 16'(cpu_int), 16'(m_win() != 8));
  endtask

  task automatic check_isr(input string tag);
    logic [7:0] d;
    rd_bus(1'b0, 1'b0, d); chk(tag, 16'(d), 16'(misr));
    rd_bus(1'b1, 1'b0, d); chk(tag, 16'(d), 16'(sisr));
  endtask

  task automatic set_mask(input logic sel, input logic [7:0] m);
    wr_bus(sel, 1'b1, m);
    if (sel) smask = m; else mmask = m;
  endtask

  task automatic init_all(input logic [4:0] mb, input logic [4:0] sb, input logic [7:0] mode);
    wr_bus(1'b0, 1'b0, 8'h11); wr_bus(1'b0, 1'b1, {mb, 3'b000});
    wr_bus(1'b0, 1'b1, 8'h04); wr_bus(1'b0, 1'b1, mode | 8'h01);
    wr_bus(1'b1, 1'b0, 8'h11); wr_bus(1'b1, 1'b1, {sb, 3'b000});
    wr_bus(1'b1, 1'b1, 8'h02); wr_bus(1'b1, 1'b1, mode | 8'h01);
    mbase = mb; sbase = sb; mmask = '0; smask = '0; misr = '0; sisr = '0;
    aeoi_m = mode[1]; sfnm_m = mode[4]; ready_m = 1;
  endtask

  task automatic do_ack(input string tag);
    int mw, sw;
    logic [7:0] expv;
    mw = m_win();
    if (mw == 8) expv = {mbase, 3'd7};
    else if (mw == 2) begin
      sw = s_win();
      expv = {sbase, (sw == 8) ? 3'd7 : 3'(sw)};
      if (!aeoi_m) begin
        misr[2] = 1'b1;
        if (sw != 8) sisr[sw] = 1'b1;
      end
    end else begin
      expv = {mbase, 3'(mw)};
      if (!aeoi_m) misr[mw] = 1'b1;
    end
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    @(negedge clk);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk({tag, " vec_valid"}, 16'(vec_valid), 16'd1);
    chk({tag, " vector"}, 16'(vec), 16'(expv));
    check_isr({tag, " R8 isr"});
  endtask

  task automatic eoi_ns(input logic sel);
    int b;
    wr_bus(sel, 1'b0, 8'h20);
    if (sel) begin b = low_bit(sisr); if (b != 8) sisr[b] = 1'b0; end
    else     begin b = low_bit(misr); if (b != 8) misr[b] = 1'b0; end
  endtask

  task automatic eoi_sp(input logic sel, input int n);
    wr_bus(sel, 1'b0, 8'h60 | 8'(n));
    if (sel) sisr[n] = 1'b0; else misr[n] = 1'b0;
  endtask

  task automatic random_phase(input logic [7:0] mode);
    int op, b;
    logic [7:0] d;
    init_all(5'h04, 5'h15, mode);
    for (int it = 0; it < 40; it++) begin
      op = $urandom % 5;
      if (op <= 1) set_lines(16'($urandom & $urandom) & 16'hFFFB);
      else if (op == 2) begin
        if ($urandom % 2) set_mask(1'b1, 8'($urandom & $urandom));
        else set_mask(1'b0, 8'($urandom & $urandom & 32'hFB));
        rd_bus(1'b0, 1'b1, d); chk("R3 mask readback", 16'(d), 16'(mmask));
      end else begin
        b = low_bit(misr);
        eoi_ns(1'b0);
        if (b == 2) eoi_ns(1'b1);
      end
      check_int("R4 random int");
      if (cpu_int) do_ack(aeoi_m ? "R9 random ack" : "R5 random ack");
    end
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1C3A));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 cpu_int", 16'(cpu_int), 16'd0);
    chk("R1 vec_valid", 16'(vec_valid), 16'd0);
    rd_bus(1'b0, 1'b1, d); chk("R1 mask", 16'(d), 16'h00);
    wr_bus(1'b0, 1'b1, 8'hFF);
    set_lines(16'h0001);
    repeat (4) @(negedge clk);
    chk("R1 no int before init", 16'(cpu_int), 16'd0);
    rd_bus(1'b0, 1'b1, d); chk("R1 odd write ignored", 16'(d), 16'h00);

    // R2: initialization, normal mode
    set_lines(16'h0000);
    init_all(5'h01, 5'h0E, 8'h00);
    rd_bus(1'b0, 1'b1, d); chk("R2 master mask", 16'(d), 16'h00);
    rd_bus(1'b1, 1'b1, d); chk("R2 slave mask", 16'(d), 16'h00);

    // R4/R5: simple grant and vector
    set_lines(16'h0001);
    check_int("R4 line0 int");
    do_ack("R5 line0");
    set_lines(16'h0003);
    check_int("R4 lower blocked");
    set_lines(16'h0002);
    eoi_ns(1'b0);
    check_int("R8 after eoi");
    do_ack("R4 line1");
    set_lines(16'h0000);
    eoi_ns(1'b0);
    check_isr("R8 nonspecific eoi");

    // R6: bit 2 ignored, slave vector
    set_lines(16'h0004);
    check_int("R6 line2 ignored");
    set_lines(16'h2000);
    check_int("R6 slave int");
    do_ack("R6 slave vector");
    set_lines(16'h0000);
    eoi_sp(1'b1, 5);
    eoi_sp(1'b0, 2);
    check_isr("R8 specific eoi");

    // R7: master bit 2 gates the slave
    set_mask(1'b0, 8'h04);
    set_lines(16'h0100);
    check_int("R7 slave blocked");
    rd_bus(1'b0, 1'b1, d); chk("R3 mask readback", 16'(d), 16'h04);
    set_mask(1'b0, 8'h00);
    check_int("R7 slave released");
    do_ack("R6 slave line0");
    set_lines(16'h0000);
    eoi_ns(1'b1); eoi_ns(1'b0);

    // R3: mask blocks a line
    set_mask(1'b0, 8'h01);
    set_lines(16'h0001);
    check_int("R3 masked");
    set_lines(16'h0000);
    set_mask(1'b0, 8'h00);

    // R11: spurious acknowledge
    check_int("R11 idle");
    do_ack("R11 spurious");

    // R9: automatic end of interrupt
    init_all(5'h01, 5'h0E, 8'h02);
    set_lines(16'h0008);
    check_int("R9 master int");
    do_ack("R9 master");
    set_lines(16'h0800);
    check_int("R9 slave int");
    do_ack("R9 slave");
    set_lines(16'h8000);
    check_int("R9 slave lower granted");
    do_ack("R9 slave lower");
    set_lines(16'h0000);

    // R10: special fully nested mode
    init_all(5'h01, 5'h0E, 8'h10);
    set_lines(16'h2000);
    check_int("R10 first");
    do_ack("R10 first slave");
    set_lines(16'h2800);
    check_int("R10 nested int");
    do_ack("R10 nested slave");
    set_lines(16'h0000);

    // random phases
    random_phase(8'h00);
    random_phase(8'h02);
    random_phase(8'h10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule